// File: doc/BRIEF.md
# Interrupt Combiner Register Bank

This block folds many level-sensitive interrupt lines into a smaller set of combined lines for a parent interrupt controller. The lines come in groups of eight. Each group has its own eight enable bits and drives one output, which is high whenever at least one of its enabled lines is high. The number of groups is a parameter. Groups are packed four to a 16-byte register bank, one byte lane per group.

Software sees a 32-bit word port. One offset sets enable bits. Another clears them. A third shows which enabled lines are currently active. Setting and clearing use separate addresses, so a driver never does a read-modify-write on the enables. Reads are combinational on the current address. Writes land on the next clock edge.

Top module: `irq_combiner_bank`

## Requirements
- R1: After reset every enable bit is 0, every `irq_out` bit is low and every readable offset returns zero.
- R2: A write at bank offset 0x0 enables each line whose data bit is 1; data bits that are 0 leave their enable unchanged; the change is visible from the next clock edge.
- R3: A write at bank offset 0x4 disables each line whose data bit is 1; data bits that are 0 leave their enable unchanged.
- R4: Group n belongs to the bank at byte offset (n div 4)*0x10 and uses data bits [8*(n mod 4)+7 : 8*(n mod 4)]; line j of group n is `irq_in[8*n+j]` and maps to bit 8*(n mod 4)+j.
- R5: `irq_out[n]` is high in the same cycle as any line of group n that is both enabled and high, and low otherwise (level behaviour, no latching).
- R6: A read at bank offset 0xC returns, in each group's byte lane, the live line levels ANDed with that group's enables.
- R7: Reads at bank offsets 0x0 and 0x4 both return the current enable bits in each group's byte lane.
- R8: Offset 0x8, byte addresses with a nonzero low two bits, banks with no groups, and lanes with no group read as zero; writes to such addresses change no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | 8*NUM_GROUPS | Level-sensitive interrupt lines, group n in bits 8n+7..8n |
| irq_out | output | NUM_GROUPS | Combined line per group |

## Verification
The assertions assume `irq_in`, `reg_wr`, `reg_addr` and `reg_wdata` are already in the clock domain and settled before each rising edge. They also assume reset is held for at least one edge at start-up. The stimulus meets this by changing every input only on the falling edge. It issues single-cycle write pulses and sweeps line patterns while the enables stay still, so each status and output check sees one stable combination.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  localparam int GRP_W        = 8;
  localparam int GRP_PER_BANK = 4;
  localparam int REG_W        = 32;

  typedef enum logic [1:0] {
    SEL_EN_SET = 2'd0,
    SEL_EN_CLR = 2'd1,
    SEL_HOLE   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // bank that holds a group
  function automatic int bank_of(input int grp);
    return grp / GRP_PER_BANK;
  endfunction

  // lowest data bit of a group's byte lane
  function automatic int lane_lsb(input int grp);
    return (grp % GRP_PER_BANK) * GRP_W;
  endfunction

endpackage

// File: rtl/irq_comb_decode.sv
module irq_comb_decode
  import irq_comb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [NUM_BANKS-1:0] set_stb,
  output logic [NUM_BANKS-1:0] clr_stb,
  output reg_sel_e             sel
);
  localparam int BIDX_W = ADDR_W - 4;

  logic              aligned;
  logic [BIDX_W-1:0] bidx;

  assign aligned = (addr[1:0] == 2'b00);
  assign bidx    = addr[ADDR_W-1:4];
  assign sel     = reg_sel_e'(addr[3:2]);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign bank_hit[k] = aligned && (bidx == BIDX_W'(k));
    assign set_stb[k]  = wr_en && bank_hit[k] && (sel == SEL_EN_SET);
    assign clr_stb[k]  = wr_en && bank_hit[k] && (sel == SEL_EN_CLR);
  end

  // R2 / R3: one write touches at most one bank and one kind of update
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb}));

  // R8: misaligned addresses select no bank
  p_misaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (bank_hit == '0));

endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_comb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [GRP_W-1:0] wbits,
  input  logic [GRP_W-1:0] lines,
  output logic [GRP_W-1:0] en,
  output logic [GRP_W-1:0] pend,
  output logic             line_out
);

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= '0;
    else if (set_stb) en <= en | wbits;
    else if (clr_stb) en <= en & ~wbits;
  end

  assign pend     = lines & en;
  assign line_out = |pend;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (en == '0));

  // R2: ones turn on, zeros keep
  p_set_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en & $past(wbits)) == $past(wbits)));
  p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en & ~$past(wbits)) == ($past(en) & ~$past(wbits))));

  // R3: ones turn off, zeros keep
  p_clr_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en & $past(wbits)) == '0));
  p_clr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en & ~$past(wbits)) == ($past(en) & ~$past(wbits))));

  // R8: no strobe, no change
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(en));

endmodule

// File: rtl/irq_combiner_bank.sv
module irq_combiner_bank
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic [NUM_GROUPS*GRP_W-1:0] irq_in,
  output logic [NUM_GROUPS-1:0]       irq_out
);
  localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;

  logic [NUM_BANKS-1:0]              bank_hit, set_stb, clr_stb;
  reg_sel_e                          sel;
  logic [NUM_GROUPS-1:0][GRP_W-1:0]  en_g, pend_g;
  logic [NUM_GROUPS-1:0][REG_W-1:0]  rd_part;

  irq_comb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .bank_hit (bank_hit),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .sel      (sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BK  = bank_of(g);
    localparam int LSB = lane_lsb(g);

    irq_comb_group u_group (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_stb  (set_stb[BK]),
      .clr_stb  (clr_stb[BK]),
      .wbits    (reg_wdata[LSB +: GRP_W]),
      .lines    (irq_in[g*GRP_W +: GRP_W]),
      .en       (en_g[g]),
      .pend     (pend_g[g]),
      .line_out (irq_out[g])
    );

    assign rd_part[g] =
      !bank_hit[BK]                              ? '0 :
      (sel == SEL_STATUS)                        ? (REG_W'(pend_g[g]) << LSB) :
      (sel == SEL_EN_SET || sel == SEL_EN_CLR)   ? (REG_W'(en_g[g])   << LSB) :
                                                   '0;

    // R6: status lane equals live lines masked by enables
    p_status_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_hit[BK] && sel == SEL_STATUS) |->
        (reg_rdata[LSB +: GRP_W] == (irq_in[g*GRP_W +: GRP_W] & en_g[g])));

    // R7: enable view on both update offsets
    p_enable_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_hit[BK] && (sel == SEL_EN_SET || sel == SEL_EN_CLR)) |->
        (reg_rdata[LSB +: GRP_W] == en_g[g]));

    // R5: a high output needs a high raw line and a set enable
    p_out_needs_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[g] |-> ((|irq_in[g*GRP_W +: GRP_W]) && (|en_g[g])));
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) reg_rdata = reg_rdata | rd_part[g];
  end

  // R8: the unused offset reads zero
  p_hole_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HOLE) |-> (reg_rdata == '0));

endmodule

// File: tb/irq_combiner_bank_tb.sv
`timescale 1ns/1ps
module irq_combiner_bank_tb;
  localparam int NG = 6;
  localparam int AW = 8;
  localparam int NL = NG * 8;
  localparam int NB = (NG + 3) / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NG-1:0] irq_out;
  logic [NL-1:0] en_m = '0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_combiner_bank #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    logic [31:0] r = '0;
    int bank = int'(a) / 16;
    int s = int'(a[3:2]);
    if (a[1:0] != 2'b00 || s == 2) return '0;
    for (int ln = 0; ln < 4; ln++) begin
      int g = bank * 4 + ln;
      if (g < NG) begin
        logic [7:0] b;
        b = (s == 3) ? (irq_in[g*8 +: 8] & en_m[g*8 +: 8]) : en_m[g*8 +: 8];
        r = r | (32'(b) << (8 * ln));
      end
    end
    return r;
  endfunction

  function automatic logic [NG-1:0] exp_out();
    logic [NG-1:0] o;
    for (int g = 0; g < NG; g++) o[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
    return o;
  endfunction

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
    int bank = int'(a) / 16;
    int s = int'(a[3:2]);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a[1:0] == 2'b00 && (s == 0 || s == 1)) begin
      for (int ln = 0; ln < 4; ln++) begin
        int g = bank * 4 + ln;
        if (g < NG) begin
          if (s == 0) en_m[g*8 +: 8] = en_m[g*8 +: 8] | d[8*ln +: 8];
          else        en_m[g*8 +: 8] = en_m[g*8 +: 8] & ~d[8*ln +: 8];
        end
      end
    end
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp_rd(a));
  endtask

  task automatic out_chk(input string req);
    #1;
    chk(req, 32'(irq_out), 32'(exp_out()));
  endtask

  task automatic sweep_all(input string req);
    for (int a = 0; a < 16 * (NB + 1); a += 4) rd_chk(req, AW'(a));
    rd_chk(req, AW'(8'h01));
    rd_chk(req, AW'(8'h1E));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_in = '1;
    // R1: everything quiet after reset even with all lines high
    sweep_all("R1");
    out_chk("R1");

    // R2, R4, R5, R6, R7: walk a single enable bit on through every line
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < 8; b++) begin
        logic [AW-1:0] base = AW'((g / 4) * 16);
        do_wr(base, 32'(1) << (8 * (g % 4) + b));
        rd_chk("R2_R4", base);
        rd_chk("R7", base + AW'(4));
        rd_chk("R6", base + AW'(12));
        out_chk("R5");
      end
    end
    // R2: all-zero set write changes nothing
    do_wr(8'h00, 32'h0);
    rd_chk("R2", 8'h00);

    // R3: walk enables off again
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < 8; b += 3) begin
        logic [AW-1:0] base = AW'((g / 4) * 16);
        do_wr(base + AW'(4), 32'(1) << (8 * (g % 4) + b));
        rd_chk("R3", base);
        out_chk("R3_R5");
      end
    end
    do_wr(8'h14, 32'h0);
    rd_chk("R3", 8'h10);

    // R5 / R6: line patterns against a mixed enable set
    do_wr(8'h00, 32'hF0C3_A55A);
    do_wr(8'h10, 32'h0000_7E81);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      irq_in = NL'((64'(k + 1) * 64'h9E37_79B9_7F4A_7C15) >> (k % 9));
      rd_chk("R6", 8'h0C);
      rd_chk("R6", 8'h1C);
      out_chk("R5");
    end
    // R5: dropping lines drops outputs in the same cycle
    @(negedge clk);
    irq_in = '0;
    out_chk("R5");
    irq_in = '1;
    out_chk("R5");

    // R8: writes to holes, misaligned and missing banks change nothing
    do_wr(8'h08, 32'hFFFF_FFFF);
    do_wr(8'h01, 32'hFFFF_FFFF);
    do_wr(8'h05, 32'hFFFF_FFFF);
    do_wr(8'h20, 32'hFFFF_FFFF);
    do_wr(8'h1A, 32'hFFFF_FFFF);
    sweep_all("R8");
    out_chk("R8");
    do_wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R8", 8'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule